// File: doc/BRIEF.md
# GCD Engine with Quadruple-Subtract Fast Path

This block computes the greatest common divisor of two non-zero unsigned operands by repeated subtraction. It keeps two working registers. On every iteration cycle the larger register is reduced by the smaller one, and the loop ends when the two are equal. The common pattern in this loop is a run of several reductions of the first register. A detector handles that pattern: it forms the first register minus four times the second, one bit wider than needed so that the sign is correct. When that difference is strictly positive, four ordinary iterations would all have reduced the first register, so the detector applies all four in a single cycle. Otherwise the ordinary single subtraction is used.

An operation begins with a one-cycle start strobe that carries both operands. The block raises busy while it iterates and then gives a one-cycle done pulse. At that pulse the result, an error flag and the number of iteration cycles are valid, and they hold until the next accepted start. A zero operand is not iterated. It produces a done pulse with the error flag set.

Top module: `gcd_fastpath`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0, and gcd_o and cycles_o are 0.
- R2: A start strobe with two non-zero operands, sampled while busy_o is low, makes busy_o high from the next cycle. busy_o never rises without a start in the cycle before.
- R3: For non-zero operands, gcd_o equals the greatest common divisor of the two operands while done_o is high. gcd_o keeps that value afterwards.
- R4: In an iteration cycle where x > 4·y (the difference x − 4y is strictly positive), x becomes x − 4y in that one cycle. When x equals exactly 4·y, the ordinary step is taken.
- R5: In an iteration cycle that is not a fast step, x becomes x − y if x > y, and y becomes y − x if y > x. The register that is not reduced keeps its value.
- R6: cycles_o counts the iteration cycles in which x ≠ y. When done_o is high, it equals the step count of the fast-path algorithm. Done comes one cycle after the last step, so equal operands give done two cycles after start, with cycles_o = 0.
- R7: A start with either operand zero produces done_o in the next cycle with err_o = 1, gcd_o = 0 and cycles_o = 0. busy_o stays low.
- R8: A start strobe while busy_o is high is ignored. The running operation completes with its own result and step count.
- R9: done_o is high for exactly one cycle per operation, and busy_o is low whenever done_o is high.
- R10: err_o stays set until the next accepted start with non-zero operands clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, one cycle |
| opa_i | input | WIDTH | First operand (x), sampled with start |
| opb_i | input | WIDTH | Second operand (y), sampled with start |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation had a zero operand |
| gcd_o | output | WIDTH | Result of the last operation |
| cycles_o | output | CNT_W | Iteration cycles taken by the last operation |

## Verification
The bench instantiates the block with WIDTH = 12 and CNT_W = 16. With these values, full-scale operands such as (4095, 1) finish in about a thousand cycles, and 4·y regularly overflows the operand width. That exercises the wider signed difference at its top bit. Random operand pairs, the exact x = 4·y boundary, equal operands, zero operands and mid-run start strobes are each compared, cycle by cycle, against a behavioural model of the handshake and step count.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    // Kind of update applied to the working registers in one cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,   // x == y, nothing to do
        STEP_XSUB = 2'd1,   // x <= x - y
        STEP_QUAD = 2'd2,   // x <= x - 4y (four x-steps in one)
        STEP_YSUB = 2'd3    // y <= y - x
    } step_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fsm_e;

    // A fast step is legal only when the wide difference is strictly positive
    function automatic logic quad_legal(input logic sign_bit, input logic is_zero);
        return !sign_bit && !is_zero;
    endfunction

endpackage

// File: rtl/gcd_select.sv
module gcd_select
    import gcd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output step_e            kind_o,
    output logic [WIDTH-1:0] x_nx_o,
    output logic [WIDTH-1:0] y_nx_o
);
    // Three extra bits: two for the shift by two, one for the sign
    localparam int EW = WIDTH + 3;

    logic [EW-1:0] x_wide;
    logic [EW-1:0] quad_y;
    logic [EW-1:0] diff;
    logic          quad_ok;

    assign x_wide  = {3'b000, x_i};
    assign quad_y  = {1'b0, y_i, 2'b00};
    assign diff    = x_wide - quad_y;
    assign quad_ok = quad_legal(diff[EW-1], diff == '0);

    always_comb begin
        x_nx_o = x_i;
        y_nx_o = y_i;
        if (x_i == y_i) begin
            kind_o = STEP_HOLD;
        end else if (quad_ok) begin
            kind_o = STEP_QUAD;
            x_nx_o = diff[WIDTH-1:0];
        end else if (x_i > y_i) begin
            kind_o = STEP_XSUB;
            x_nx_o = x_i - y_i;
        end else begin
            kind_o = STEP_YSUB;
            y_nx_o = y_i - x_i;
        end
    end

    // R4
    always_comb begin
        if (kind_o == STEP_QUAD) begin
            quad_implies_xgt_chk: assert (x_i > y_i && x_nx_o < x_i);
        end
    end

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             equal_o,
    output logic [WIDTH-1:0] x_o
);
    logic [WIDTH-1:0] x_q, y_q;
    logic [WIDTH-1:0] x_nx, y_nx;
    step_e            kind;

    gcd_select #(.WIDTH(WIDTH)) u_sel (
        .x_i    (x_q),
        .y_i    (y_q),
        .kind_o (kind),
        .x_nx_o (x_nx),
        .y_nx_o (y_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load_i) begin
            x_q <= a_i;
            y_q <= b_i;
        end else if (run_i) begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end

    assign equal_o = (x_q == y_q);
    assign x_o     = x_q;

    // R4
    quad_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && kind == STEP_QUAD) |=> (x_q < $past(x_q)) && $stable(y_q));

    // R5
    xsub_keeps_y_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && kind == STEP_XSUB) |=> $stable(y_q) && (x_q < $past(x_q)));

    // R5
    ysub_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && kind == STEP_YSUB) |=> $stable(x_q) && (y_q < $past(y_q)));

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             zero_i,
    input  logic             equal_i,
    input  logic [WIDTH-1:0] x_i,
    output logic             load_o,
    output logic             run_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [WIDTH-1:0] res_o,
    output logic [CNT_W-1:0] cnt_o
);
    fsm_e state_q;

    assign busy_o = (state_q == ST_RUN);
    assign run_o  = busy_o;
    assign load_o = (state_q == ST_IDLE) && start_i && !zero_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            res_o   <= '0;
            cnt_o   <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && zero_i) begin
                        done_o <= 1'b1;
                        err_o  <= 1'b1;
                        res_o  <= '0;
                        cnt_o  <= '0;
                    end else if (start_i) begin
                        state_q <= ST_RUN;
                        err_o   <= 1'b0;
                        cnt_o   <= '0;
                    end
                end
                ST_RUN: begin
                    if (equal_i) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                        res_o   <= x_i;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R7
    zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (res_o == '0 && cnt_o == '0));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !equal_i) |=> busy_o && $stable(res_o));

endmodule

// File: rtl/gcd_fastpath.sv
module gcd_fastpath #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [WIDTH-1:0] gcd_o,
    output logic [CNT_W-1:0] cycles_o
);
    logic             load, run, equal, zero_op;
    logic [WIDTH-1:0] x_cur;

    assign zero_op = (opa_i == '0) || (opb_i == '0);

    gcd_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .run_i   (run),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .equal_o (equal),
        .x_o     (x_cur)
    );

    gcd_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .zero_i  (zero_op),
        .equal_i (equal),
        .x_i     (x_cur),
        .load_o  (load),
        .run_o   (run),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .err_o   (err_o),
        .res_o   (gcd_o),
        .cnt_o   (cycles_o)
    );

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !err_o);

endmodule

// File: tb/gcd_fastpath_test.sv
`timescale 1ns/1ps
module gcd_fastpath_test;
    localparam int W  = 12;
    localparam int CW = 16;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [W-1:0]  opa_i = '0;
    logic [W-1:0]  opb_i = '0;
    logic          busy_o, done_o, err_o;
    logic [W-1:0]  gcd_o;
    logic [CW-1:0] cycles_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    gcd_fastpath #(.WIDTH(W), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .gcd_o(gcd_o), .cycles_o(cycles_o)
    );

    // ---------------- software references ----------------
    function automatic int euclid(input int a, input int b);
        int t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic int walk_steps(input int a, input int b, input bit quad);
        int x = a;
        int y = b;
        int n = 0;
        while (x != y) begin
            if (quad && x > 4 * y) x = x - 4 * y;
            else if (x > y)        x = x - y;
            else                   y = y - x;
            n++;
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- cycle-level reference model ----------------
    bit m_busy = 0, m_done = 0, m_err = 0;
    int m_left = 0, m_res = 0, m_cnt = 0, p_res = 0, p_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_err <= 0;
            m_left <= 0; m_res <= 0; m_cnt <= 0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_left == 1) begin
                    m_busy <= 0;
                    m_done <= 1;
                    m_res  <= p_res;
                    m_cnt  <= p_cnt;
                end
                m_left <= m_left - 1;
            end else if (start_i) begin
                if (opa_i == 0 || opb_i == 0) begin
                    m_done <= 1; m_err <= 1; m_res <= 0; m_cnt <= 0;
                end else begin
                    p_res  <= euclid(int'(opa_i), int'(opb_i));
                    p_cnt  <= walk_steps(int'(opa_i), int'(opb_i), 1'b1);
                    m_left <= walk_steps(int'(opa_i), int'(opb_i), 1'b1) + 1;
                    m_busy <= 1;
                    m_err  <= 0;
                end
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !ended) begin
            check(busy_o == m_busy, "R2", "busy", busy_o, m_busy);
            check(done_o == m_done, "R9", "done", done_o, m_done);
            check(err_o  == m_err,  "R10", "err", err_o, m_err);
            if (m_done) begin
                check(int'(gcd_o) == m_res, "R3", "gcd at done", gcd_o, m_res);
                check(int'(cycles_o) == m_cnt, "R6", "cycles at done", cycles_o, m_cnt);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_start(input int a, input int b);
        @(negedge clk);
        start_i = 1'b1;
        opa_i   = W'(a);
        opb_i   = W'(b);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!m_done) @(negedge clk);
    endtask

    task automatic run_op(input int a, input int b, input string req);
        pulse_start(a, b);
        wait_done();
        check(int'(gcd_o) == euclid(a, b), req, "result", gcd_o, euclid(a, b));
        check(int'(cycles_o) == walk_steps(a, b, 1'b1), req, "steps", cycles_o,
              walk_steps(a, b, 1'b1));
        check(err_o == 1'b0, req, "no error", err_o, 0);
    endtask

    task automatic finish_run();
        ended = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !ended) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "flags after reset",
              {busy_o, done_o, err_o}, 0);
        check(gcd_o == 0 && cycles_o == 0, "R1", "values after reset", gcd_o + cycles_o, 0);

        // R3 basic
        run_op(48, 18, "R3");
        run_op(17, 5, "R3");
        // R4 fast path fewer cycles than the plain loop
        run_op(100, 3, "R4");
        check(int'(cycles_o) < walk_steps(100, 3, 1'b0), "R4", "fast path shorter",
              cycles_o, walk_steps(100, 3, 1'b0));
        // R4 boundary x == 4y takes the ordinary step: 8,2 -> 6,4,2 => 3 steps
        run_op(8, 2, "R4");
        check(cycles_o == 3, "R4", "x equal 4y steps", cycles_o, 3);
        // 9,2 -> fast to 1,2 -> y-step 1,1 => 2 steps
        run_op(9, 2, "R4");
        check(cycles_o == 2, "R4", "x just over 4y steps", cycles_o, 2);
        // R5 y branch and ordinary x steps
        run_op(5, 17, "R5");
        run_op(7, 12, "R5");
        run_op(4095, 1, "R4");
        run_op(4095, 4094, "R5");

        // R6 equal operands: done exactly two cycles after start
        @(negedge clk);
        start_i = 1'b1; opa_i = W'(42); opb_i = W'(42);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1 && done_o == 0, "R6", "equal ops busy one cycle", busy_o, 1);
        @(negedge clk);
        check(done_o == 1 && gcd_o == 42 && cycles_o == 0, "R6", "equal ops done", gcd_o, 42);

        // R7 zero operands
        pulse_start(0, 5);
        check(done_o == 1 && err_o == 1 && busy_o == 0, "R7", "zero a flagged",
              {done_o, err_o, busy_o}, 3'b110);
        check(gcd_o == 0 && cycles_o == 0, "R7", "zero a result", gcd_o, 0);
        @(negedge clk);
        check(err_o == 1 && done_o == 0, "R10", "err held", err_o, 1);
        pulse_start(9, 0);
        check(done_o == 1 && err_o == 1, "R7", "zero b flagged", err_o, 1);
        // R10 cleared by a good start
        run_op(21, 14, "R10");

        // R8 start while busy is ignored
        pulse_start(1000, 7);
        @(negedge clk);
        start_i = 1'b1; opa_i = W'(60); opb_i = W'(36);
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(gcd_o == 1, "R8", "result of first op", gcd_o, 1);
        check(int'(cycles_o) == walk_steps(1000, 7, 1'b1), "R8", "steps of first op",
              cycles_o, walk_steps(1000, 7, 1'b1));
        @(negedge clk);
        check(busy_o == 0, "R8", "no second op started", busy_o, 0);

        // random operand pairs
        for (int i = 0; i < 60; i++) begin
            int a = int'($urandom_range(1, (1 << W) - 1));
            int b = (i % 3 == 0) ? int'($urandom_range(1, 40)) : int'($urandom_range(1, (1 << W) - 1));
            run_op(a, b, "R3");
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule